// File: doc/BRIEF.md
# Time-Multiplexed Ternary Match Memory

This block is a ternary content-addressable memory built on one ordinary two-port RAM. Each stored rule holds a value and a don't-care mask. A search compares a key with every rule at once and returns the address of the matching rule, with a hit flag. The key is cut into N equal chunks. Each chunk value selects one word of a shallow sub-block. That word holds one bit per rule, and the bit is set when the rule accepts that chunk value. All N sub-blocks share a single RAM. The block clock runs N times faster than the search rate, so the sub-blocks are read one after another and a running AND combines the partial vectors within one search-rate period.

A free-running phase counter splits the block clock into search-rate slots. Requests are taken only on slot edges. A second pipeline stage finds the lowest-numbered set bit of the combined vector. Because the stages overlap, one search can be issued in every slot. A rule update uses the RAM write port. It walks every word of every sub-block and sets or clears that rule's bit. While the update runs, searches are refused.

Top module: `tmux_tcam`

## Requirements
- R1: A rule matches a key when every key bit whose mask bit is 0 equals the rule's value bit. A mask bit of 1 means don't care, and a rule can match on bits in any chunk.
- R2: When several rules match, `res_hit` is 1 and `res_addr` gives the lowest-numbered matching rule.
- R3: When no rule matches, `res_hit` is 0 and `res_addr` is 0 while `res_valid` is 1.
- R4: A rule written with `upd_enable` = 0 matches no key, whatever its value and mask.
- R5: Edges are numbered from 0 at the first rising edge after reset release. Edge k is a slot edge when k mod N is 0. A search taken at slot edge E raises `res_valid` after edge E+2N, and it stays high for exactly N cycles. Searches in consecutive slots give results in consecutive slots.
- R6: A search request seen on an edge that is not a slot edge is ignored and produces no result.
- R7: An update is taken at a slot edge when `upd_busy` is 0. `upd_busy` is then high for N·2^(KEY_W/N) cycles. Search requests made while it is high produce no result.
- R8: Writing a rule again replaces its old pattern completely.
- R9: After reset, `res_valid`, `res_hit`, `res_addr` and `upd_busy` are all 0.
- R10: When a search and an update are requested at the same slot edge, the search is taken and the update is dropped: `upd_busy` stays 0 and the rule keeps its old pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, N times the search rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_req | input | 1 | Search request, sampled on slot edges |
| srch_key | input | KEY_W | Search key |
| upd_req | input | 1 | Rule update request, sampled on slot edges |
| upd_rule | input | RULE_W | Index of the rule to write |
| upd_value | input | KEY_W | Rule value bits |
| upd_mask | input | KEY_W | Don't-care bits (1 = ignore) |
| upd_enable | input | 1 | 1 stores the rule, 0 makes it match nothing |
| upd_busy | output | 1 | Update in progress; searches refused |
| res_valid | output | 1 | Result valid for one search-rate period |
| res_hit | output | 1 | At least one rule matched |
| res_addr | output | RULE_W | Lowest matching rule index |

## Verification
The rule set mixes an exact rule, two rules that care about only one chunk (one per chunk), a catch-all rule and disabled catch-alls. Keys are chosen so that they hit several rules at once, which shows whether priority picks the lowest index, whether don't-care bits in each chunk are really ignored, and whether a disabled catch-all leaks through. Later keys check a full miss, a rule written twice, and a collision between a search and an update. Timing is probed with searches issued back to back, off-slot and during an update, and `res_valid` is sampled on the cycles on either side of the expected window.

// File: rtl/tmux_tcam_pkg.sv
package tmux_tcam_pkg;
    typedef enum logic [0:0] {
        UPD_IDLE  = 1'b0,
        UPD_WRITE = 1'b1
    } upd_state_e;
endpackage

// File: rtl/tmux_tcam_bitram.sv
module tmux_tcam_bitram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 512,
    parameter int AW    = 9,
    parameter int IW    = 9
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [IW-1:0]    wr_bit,
    input  logic             wr_val
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Read port returns a whole match word one cycle later; write port changes one rule bit.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr][wr_bit] <= wr_val;
        if (rd_en) rd_data <= mem_q[rd_addr];
    end
endmodule

// File: rtl/tmux_tcam_prio_enc.sv
module tmux_tcam_prio_enc #(
    parameter int WIDTH = 512,
    parameter int IW    = 9
) (
    input  logic [WIDTH-1:0] vec,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        hit = |vec;
    end
endmodule

// File: rtl/tmux_tcam.sv
module tmux_tcam
    import tmux_tcam_pkg::*;
#(
    parameter int RULES = 512,
    parameter int KEY_W = 28,
    parameter int N     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     srch_req,
    input  logic [KEY_W-1:0]         srch_key,
    input  logic                     upd_req,
    input  logic [$clog2(RULES)-1:0] upd_rule,
    input  logic [KEY_W-1:0]         upd_value,
    input  logic [KEY_W-1:0]         upd_mask,
    input  logic                     upd_enable,
    output logic                     upd_busy,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [$clog2(RULES)-1:0] res_addr
);
    localparam int RULE_W  = $clog2(RULES);
    localparam int CHUNK_W = KEY_W / N;
    localparam int PH_W    = (N > 1) ? $clog2(N) : 1;
    localparam int ADDR_W  = PH_W + CHUNK_W;
    localparam int DEPTH   = N << CHUNK_W;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic              s_act;
        logic [PH_W-1:0]   s_cnt;
        logic [KEY_W-1:0]  s_key;
        logic [RULES-1:0]  s_acc;
        logic              m_valid;
        logic [RULES-1:0]  m_vec;
        logic              r_valid;
        logic              r_hit;
        logic [RULE_W-1:0] r_addr;
        upd_state_e        u_state;
        logic [ADDR_W-1:0] u_cnt;
        logic [RULE_W-1:0] u_rule;
        logic [KEY_W-1:0]  u_val;
        logic [KEY_W-1:0]  u_mask;
        logic              u_en;
    } st_t;

    localparam st_t RESET_ST = '0;

    st_t st_d, st_q;

    logic              slot, s_accept, u_accept, u_act;
    logic              rd_en, wr_en, wr_val;
    logic [ADDR_W-1:0] rd_addr;
    logic [RULES-1:0]  rd_data, acc_new, below;
    logic              enc_hit;
    logic [RULE_W-1:0] enc_idx;
    logic [PH_W-1:0]   w_sub;
    logic [CHUNK_W-1:0] w_chunk, w_vch, w_mch;

    function automatic logic [CHUNK_W-1:0] chunk_of(input logic [KEY_W-1:0] k, input int unsigned i);
        return CHUNK_W'(k >> (i * CHUNK_W));
    endfunction

    tmux_tcam_bitram #(.DEPTH(DEPTH), .WIDTH(RULES), .AW(ADDR_W), .IW(RULE_W)) u_ram (
        .clk(clk), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(st_q.u_cnt), .wr_bit(st_q.u_rule), .wr_val(wr_val)
    );

    tmux_tcam_prio_enc #(.WIDTH(RULES), .IW(RULE_W)) u_enc (
        .vec(st_q.m_vec), .hit(enc_hit), .idx(enc_idx)
    );

    always_comb begin
        st_d     = st_q;
        u_act    = (st_q.u_state == UPD_WRITE);
        slot     = (st_q.phase == '0);
        s_accept = slot && srch_req && !u_act;
        u_accept = slot && upd_req && !srch_req && !u_act;
        acc_new  = st_q.s_acc & rd_data;
        below    = (RULES'(1) << enc_idx) - RULES'(1);

        // search-rate slot counter
        st_d.phase = (st_q.phase == PH_W'(N - 1)) ? '0 : st_q.phase + 1'b1;

        // sequential sub-block reads
        rd_en   = 1'b0;
        rd_addr = '0;
        if (s_accept) begin
            rd_en   = 1'b1;
            rd_addr = {PH_W'(0), chunk_of(srch_key, 0)};
        end else if (st_q.s_act && st_q.s_cnt != PH_W'(N - 1)) begin
            rd_en   = 1'b1;
            rd_addr = {st_q.s_cnt + 1'b1, chunk_of(st_q.s_key, int'(st_q.s_cnt) + 1)};
        end

        if (st_q.s_act) begin
            if (st_q.s_cnt == PH_W'(N - 1)) begin
                st_d.s_act = 1'b0;
            end else begin
                st_d.s_cnt = st_q.s_cnt + 1'b1;
                st_d.s_acc = acc_new;
            end
        end
        if (s_accept) begin
            st_d.s_act = 1'b1;
            st_d.s_cnt = '0;
            st_d.s_acc = '1;
            st_d.s_key = srch_key;
        end

        // system-rate stages: combined vector, then encoded result
        if (slot) begin
            st_d.m_valid = st_q.s_act && (st_q.s_cnt == PH_W'(N - 1));
            if (st_d.m_valid) st_d.m_vec = acc_new;
            st_d.r_valid = st_q.m_valid;
            if (st_q.m_valid) begin
                st_d.r_hit  = enc_hit;
                st_d.r_addr = enc_idx;
            end
        end

        // rule update walks every word of every sub-block
        w_sub   = st_q.u_cnt[ADDR_W-1 -: PH_W];
        w_chunk = st_q.u_cnt[CHUNK_W-1:0];
        w_vch   = chunk_of(st_q.u_val, int'(w_sub));
        w_mch   = chunk_of(st_q.u_mask, int'(w_sub));
        wr_en   = u_act;
        wr_val  = st_q.u_en && (((w_chunk ^ w_vch) & ~w_mch) == '0);
        if (u_act) begin
            if (st_q.u_cnt == ADDR_W'(DEPTH - 1)) st_d.u_state = UPD_IDLE;
            else                                  st_d.u_cnt = st_q.u_cnt + 1'b1;
        end
        if (u_accept) begin
            st_d.u_state = UPD_WRITE;
            st_d.u_cnt   = '0;
            st_d.u_rule  = upd_rule;
            st_d.u_val   = upd_value;
            st_d.u_mask  = upd_mask;
            st_d.u_en    = upd_enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign upd_busy  = u_act;
    assign res_valid = st_q.r_valid;
    assign res_hit   = st_q.r_hit;
    assign res_addr  = st_q.r_addr;

    // R7: the update walk never shares a cycle with a search read
    assert_port_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_en);
    // R7: an update always ends after writing the last word
    assert_update_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(u_act) |-> $past(st_q.u_cnt) == ADDR_W'(DEPTH - 1));
    // R5: a combined vector at a slot edge becomes a valid result at that edge
    assert_result_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && st_q.m_valid) |=> res_valid);
    // R5: the valid flag only changes on slot edges
    assert_valid_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(slot));
    // R6: no search starts off a slot edge
    assert_no_offslot_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot && !st_q.s_act) |=> !st_q.s_act);
    // R2: encoder output is set in the vector and nothing below it is set
    assert_lowest_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m_valid && enc_hit) |-> (st_q.m_vec[enc_idx] && ((st_q.m_vec & below) == '0)));
    // R3: a miss reports address zero
    assert_miss_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> res_addr == '0);
endmodule

// File: tb/tmux_tcam_bench.sv
`timescale 1ns/1ps
module tmux_tcam_bench;
    localparam int RULES = 16;
    localparam int KW    = 8;
    localparam int NW    = 2;
    localparam int RW    = 4;
    localparam int UPD_CYCLES = NW << (KW / NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srch_req = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          upd_req = 1'b0;
    logic [RW-1:0] upd_rule = '0;
    logic [KW-1:0] upd_value = '0;
    logic [KW-1:0] upd_mask = '0;
    logic          upd_enable = 1'b0;
    logic          upd_busy, res_valid, res_hit;
    logic [RW-1:0] res_addr;

    int checks = 0;
    int errors = 0;
    int ph = 0;

    tmux_tcam #(.RULES(RULES), .KEY_W(KW), .N(NW)) u_tmux_tcam (
        .clk(clk), .rst_n(rst_n), .srch_req(srch_req), .srch_key(srch_key),
        .upd_req(upd_req), .upd_rule(upd_rule), .upd_value(upd_value),
        .upd_mask(upd_mask), .upd_enable(upd_enable), .upd_busy(upd_busy),
        .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr)
    );

    always #4 clk = ~clk;

    // bench copy of the slot phase: 0 means the next rising edge is a slot edge
    always @(posedge clk) begin
        if (!rst_n) ph <= 0;
        else        ph <= (ph + 1) % NW;
    end

    // initial rule set: value, mask (1 = don't care), enable
    localparam logic [KW-1:0] R_VAL  [RULES] = '{8'h00, 8'hA5, 8'hA0, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00,
                                                 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    localparam logic [KW-1:0] R_MASK [RULES] = '{8'hFF, 8'h00, 8'h0F, 8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                                                 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    localparam logic          R_EN   [RULES] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                                 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    // search vectors: key, expected hit, expected address
    localparam int NV = 10;
    localparam logic [KW-1:0] V_KEY  [NV] = '{8'hA5, 8'hA7, 8'hAF, 8'hA0, 8'h35, 8'hF5, 8'h05, 8'h12, 8'h00, 8'hFF};
    localparam logic          V_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [RW-1:0] V_ADDR [NV] = '{4'd1, 4'd2, 4'd2, 4'd2, 4'd3, 4'd3, 4'd3, 4'd15, 4'd15, 4'd15};

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic goto_slot();
        @(negedge clk);
        while (ph != 0) @(negedge clk);
    endtask

    task automatic upd(input logic [RW-1:0] r, input logic [KW-1:0] v, input logic [KW-1:0] m,
                       input logic en, output int busy_len);
        goto_slot();
        upd_req = 1'b1; upd_rule = r; upd_value = v; upd_mask = m; upd_enable = en;
        @(negedge clk);
        upd_req = 1'b0;
        busy_len = 0;
        while (upd_busy && busy_len < 10000) begin
            busy_len++;
            @(negedge clk);
        end
    endtask

    task automatic search_chk(input logic [KW-1:0] key, input logic eh, input logic [RW-1:0] ea,
                              input string rq);
        goto_slot();
        srch_req = 1'b1; srch_key = key;
        @(negedge clk);
        srch_req = 1'b0;
        repeat (2 * NW - 1) @(negedge clk);
        chk(res_valid == 1'b0, "R5 valid not early", res_valid, 0);
        @(negedge clk);
        chk(res_valid == 1'b1, "R5 valid after 2N edges", res_valid, 1);
        chk(res_hit == eh, {rq, " hit"}, res_hit, eh);
        chk(res_addr == ea, {rq, " addr"}, res_addr, ea);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int blen;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
        chk(upd_busy == 1'b0, "R9 upd_busy", upd_busy, 0);
        chk(res_hit == 1'b0, "R9 res_hit", res_hit, 0);
        chk(res_addr == '0, "R9 res_addr", res_addr, 0);
        rst_n = 1'b1;

        // load rules; R7 busy length on the first write
        for (int r = 0; r < RULES; r++) begin
            upd(RW'(r), R_VAL[r], R_MASK[r], R_EN[r], blen);
            if (r == 0) chk(blen == UPD_CYCLES, "R7 busy length", blen, UPD_CYCLES);
        end

        // R1 ternary compare, R2 priority, R4 disabled rules 0 and 4..14 never win
        for (int i = 0; i < NV; i++) begin
            search_chk(V_KEY[i], V_HIT[i], V_ADDR[i], "R1/R2/R4 table");
        end

        // R6: request on an off-slot edge
        goto_slot();
        @(negedge clk);
        srch_req = 1'b1; srch_key = 8'hA5;
        @(negedge clk);
        srch_req = 1'b0;
        for (int k = 0; k < 3 * NW; k++) begin
            chk(res_valid == 1'b0, "R6 off-slot ignored", res_valid, 0);
            @(negedge clk);
        end

        // R5: back-to-back searches and valid width
        goto_slot();
        srch_req = 1'b1; srch_key = 8'hA5;
        @(negedge clk);
        while (ph != 0) @(negedge clk);
        srch_key = 8'h35;
        @(negedge clk);
        srch_req = 1'b0;
        repeat (NW) @(negedge clk);
        chk(res_valid && res_hit && res_addr == 4'd1, "R5 first of pair", {res_valid, res_hit, res_addr}, 6'h31);
        repeat (NW - 1) @(negedge clk);
        chk(res_valid && res_addr == 4'd1, "R5 first held N cycles", {res_valid, res_addr}, 5'h11);
        @(negedge clk);
        chk(res_valid && res_hit && res_addr == 4'd3, "R5 second of pair", {res_valid, res_hit, res_addr}, 6'h33);
        repeat (NW) @(negedge clk);
        chk(res_valid == 1'b0, "R5 valid drops after N cycles", res_valid, 0);

        // R7: search during update is refused; update disables catch-all rule 15 (R8)
        goto_slot();
        upd_req = 1'b1; upd_rule = 4'd15; upd_value = 8'h00; upd_mask = 8'hFF; upd_enable = 1'b0;
        @(negedge clk);
        upd_req = 1'b0;
        chk(upd_busy == 1'b1, "R7 busy after accept", upd_busy, 1);
        goto_slot();
        srch_req = 1'b1; srch_key = 8'h12;
        @(negedge clk);
        srch_req = 1'b0;
        repeat (2 * NW) @(negedge clk);
        chk(res_valid == 1'b0, "R7 search during busy ignored", res_valid, 0);
        while (upd_busy) @(negedge clk);

        // R3: full miss now that rule 15 is off
        search_chk(8'h12, 1'b0, 4'd0, "R3 miss");
        search_chk(8'hFF, 1'b0, 4'd0, "R3 R4 miss with disabled catch-alls");

        // R8: rewrite rule 1 as exact 0x12
        upd(4'd1, 8'h12, 8'h00, 1'b1, blen);
        search_chk(8'h12, 1'b1, 4'd1, "R8 new pattern");
        search_chk(8'hA5, 1'b1, 4'd2, "R8 old pattern gone");

        // R10: search and update at the same slot
        goto_slot();
        srch_req = 1'b1; srch_key = 8'hA5;
        upd_req = 1'b1; upd_rule = 4'd3; upd_value = 8'h00; upd_mask = 8'h00; upd_enable = 1'b0;
        @(negedge clk);
        srch_req = 1'b0; upd_req = 1'b0;
        chk(upd_busy == 1'b0, "R10 update dropped", upd_busy, 0);
        repeat (2 * NW - 1) @(negedge clk);
        @(negedge clk);
        chk(res_valid && res_hit && res_addr == 4'd2, "R10 search taken", {res_valid, res_hit, res_addr}, 6'h32);
        search_chk(8'h35, 1'b1, 4'd3, "R10 rule 3 untouched");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule